// File: doc/BRIEF.md
# Single-Channel PWM Generator with Atomic Update Lock

This block produces one pulse-width-modulated output from a free-running counter. Software programs it through a small APB-style register port: a period count, a duty count and a control word. All counts are in cycles of the block clock, with no prescaler, so a 25 kHz wave with 60% high time from a 100 MHz clock is a period of 4000 and a duty of 2400. That kind of setting is typical for setting the speed of a motor.

The control word selects the output level during the duty portion and, separately, the level driven while the channel is stopped. This lets software choose normal or inverted polarity. A lock bit lets software rewrite period and duty while the channel keeps running on the old pair. Clearing the lock releases both values together. A released pair is adopted only when the counter wraps, so a pulse is never cut short.

Only the left-aligned, continuous mode is built. The alignment and low-power fields read back as zero.

Top module: `pwm_lock_gen`

## Requirements
- R1: After reset, every readable register returns 0 and `pwm_o` is 0.
- R2: Registers sit at byte offsets 0x00 (live counter, read-only), 0x04 (period), 0x08 (duty) and 0x0C (control). Period and duty read back the last value written, even while the lock is set. Control stores bit 0 (enable), bit 1 (continuous), bit 3 (duty level), bit 4 (idle level) and bit 6 (lock); all other bits, including bit 5 (alignment) and bit 8 (low power), read as 0.
- R3: The generator runs only while control bits 0 and 1 are both 1. At any other time the counter reads 0 and `pwm_o` equals control bit 4.
- R4: While running, the counter steps by one each clock from 0 up to period-1 and then returns to 0. A period of 0 or 1 keeps it at 0.
- R5: While running, `pwm_o` one clock after a counter value equals control bit 3 if that value is below duty, and the inverse of bit 3 otherwise. Each period therefore holds exactly duty cycles at the bit 3 level.
- R6: A duty of 0 gives a constant inverse-of-bit-3 level while running. A duty at or above the period gives a constant bit 3 level.
- R7: While control bit 6 is 1, newly written period and duty values do not affect the counter or the output.
- R8: Clearing bit 6 releases the staged period and duty together. The counter completes the current period at the old length, and the new pair applies from the next wrap.
- R9: With the lock clear, a new period also applies only from the next counter wrap.
- R10: Writes to the counter offset, to unaligned addresses and to offsets above 0x0C change nothing. Reads from unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; also the PWM count clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Register port select |
| penable_i | input | 1 | Access phase strobe; a write commits when select, enable and write are all high |
| pwrite_i | input | 1 | 1 for write, 0 for read |
| paddr_i | input | ADDR_W (5) | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid combinationally for the address presented |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions assume that bus writes follow the two-phase setup-then-access order. They also assume that software leaves the period unchanged inside a cycle only through the staging path, never by forcing the counter. The bench drives every access with a setup phase followed by one access phase, and starts each write that changes the period a known number of cycles after counter value 1. As a result, the counter wrap that adopts the new pair falls at a predictable boundary. Each vector is measured by counting high cycles over a whole number of periods, so the result does not depend on where the window starts.

// File: rtl/pwm_lock_pkg.sv
package pwm_lock_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    REG_CNT    = 2'd0,
    REG_PERIOD = 2'd1,
    REG_DUTY   = 2'd2,
    REG_CTRL   = 2'd3
  } reg_sel_e;

  localparam int unsigned CTL_EN       = 0;
  localparam int unsigned CTL_CONT     = 1;
  localparam int unsigned CTL_DUTY_LVL = 3;
  localparam int unsigned CTL_IDLE_LVL = 4;
  localparam int unsigned CTL_LOCK     = 6;

  typedef struct packed {
    logic lock;
    logic idle_lvl;
    logic duty_lvl;
    logic cont;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pwm_lock_regs.sv
module pwm_lock_regs
  import pwm_lock_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [BUS_W-1:0]  pwdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [BUS_W-1:0]  prdata_o,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  rel_period_o,
  output logic [CNT_W-1:0]  rel_duty_o
);
  logic [CNT_W-1:0] stg_period_q, stg_duty_q;
  logic [CNT_W-1:0] rel_period_q, rel_duty_q;
  ctrl_t            ctrl_q;
  logic             hit, wr_en;
  reg_sel_e         sel;
  logic             unused_wdata;

  assign unused_wdata = ^pwdata_i;

  // word-aligned and inside the 16-byte window
  assign hit   = ((paddr_i >> 4) == '0) && (paddr_i[1:0] == 2'b00);
  assign sel   = reg_sel_e'(paddr_i[3:2]);
  assign wr_en = psel_i & penable_i & pwrite_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_period_q <= '0;
      stg_duty_q   <= '0;
      ctrl_q       <= '0;
    end else if (wr_en) begin
      unique case (sel)
        REG_PERIOD: stg_period_q <= pwdata_i[CNT_W-1:0];
        REG_DUTY:   stg_duty_q   <= pwdata_i[CNT_W-1:0];
        REG_CTRL: begin
          ctrl_q.en       <= pwdata_i[CTL_EN];
          ctrl_q.cont     <= pwdata_i[CTL_CONT];
          ctrl_q.duty_lvl <= pwdata_i[CTL_DUTY_LVL];
          ctrl_q.idle_lvl <= pwdata_i[CTL_IDLE_LVL];
          ctrl_q.lock     <= pwdata_i[CTL_LOCK];
        end
        default: ;
      endcase
    end
  end

  // released pair: frozen while locked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_period_q <= '0;
      rel_duty_q   <= '0;
    end else if (!ctrl_q.lock) begin
      rel_period_q <= stg_period_q;
      rel_duty_q   <= stg_duty_q;
    end
  end

  always_comb begin
    prdata_o = '0;
    if (hit) begin
      unique case (sel)
        REG_CNT:    prdata_o = BUS_W'(cnt_i);
        REG_PERIOD: prdata_o = BUS_W'(stg_period_q);
        REG_DUTY:   prdata_o = BUS_W'(stg_duty_q);
        REG_CTRL: begin
          prdata_o[CTL_EN]       = ctrl_q.en;
          prdata_o[CTL_CONT]     = ctrl_q.cont;
          prdata_o[CTL_DUTY_LVL] = ctrl_q.duty_lvl;
          prdata_o[CTL_IDLE_LVL] = ctrl_q.idle_lvl;
          prdata_o[CTL_LOCK]     = ctrl_q.lock;
        end
        default: ;
      endcase
    end
  end

  assign ctrl_o       = ctrl_q;
  assign rel_period_o = rel_period_q;
  assign rel_duty_o   = rel_duty_q;
endmodule

// File: rtl/pwm_lock_counter.sv
module pwm_lock_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] rel_period_i,
  input  logic [CNT_W-1:0] rel_duty_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] act_period_o,
  output logic [CNT_W-1:0] act_duty_o
);
  logic [CNT_W-1:0] cnt_q, act_period_q, act_duty_q, last;

  assign last   = (act_period_q == '0) ? '0 : act_period_q - CNT_W'(1);
  assign wrap_o = (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      act_period_q <= '0;
      act_duty_q   <= '0;
    end else if (!run_i || wrap_o) begin
      // stopped or period boundary: adopt released pair
      cnt_q        <= '0;
      act_period_q <= rel_period_i;
      act_duty_q   <= rel_duty_i;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o        = cnt_q;
  assign act_period_o = act_period_q;
  assign act_duty_o   = act_duty_q;
endmodule

// File: rtl/pwm_lock_out.sv
module pwm_lock_out #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] act_duty_i,
  input  logic             duty_lvl_i,
  input  logic             idle_lvl_i,
  output logic             pwm_o
);
  logic pwm_q, pwm_d;

  always_comb begin
    if (!run_i)                 pwm_d = idle_lvl_i;
    else if (cnt_i < act_duty_i) pwm_d = duty_lvl_i;
    else                        pwm_d = ~duty_lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm_lock_gen.sv
module pwm_lock_gen
  import pwm_lock_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pwm_o
);
  ctrl_t            ctrl;
  logic             run, wrap, lock, duty_lvl, idle_lvl;
  logic [CNT_W-1:0] cnt, rel_period, rel_duty, act_period, act_duty;

  assign run      = ctrl.en & ctrl.cont;
  assign lock     = ctrl.lock;
  assign duty_lvl = ctrl.duty_lvl;
  assign idle_lvl = ctrl.idle_lvl;

  pwm_lock_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i,
    .cnt_i(cnt), .prdata_o, .ctrl_o(ctrl),
    .rel_period_o(rel_period), .rel_duty_o(rel_duty)
  );

  pwm_lock_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run),
    .rel_period_i(rel_period), .rel_duty_i(rel_duty),
    .cnt_o(cnt), .wrap_o(wrap),
    .act_period_o(act_period), .act_duty_o(act_duty)
  );

  pwm_lock_out #(.CNT_W(CNT_W)) u_out (
    .clk_i, .rst_ni, .run_i(run), .cnt_i(cnt), .act_duty_i(act_duty),
    .duty_lvl_i(duty_lvl), .idle_lvl_i(idle_lvl), .pwm_o
  );
endmodule

// File: rtl/pwm_lock_gen_chk.sv
module pwm_lock_gen_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             wrap,
  input logic             lock,
  input logic             duty_lvl,
  input logic             idle_lvl,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_period,
  input logic [CNT_W-1:0] act_duty,
  input logic [CNT_W-1:0] rel_period,
  input logic [CNT_W-1:0] rel_duty,
  input logic             pwm_o
);
  assert_idle_cnt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> cnt == '0);

  assert_idle_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> pwm_o == $past(idle_lvl));

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_period != '0) |-> cnt < act_period);

  assert_wrap_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && wrap) |=> cnt == '0);

  assert_active_lvl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt < act_duty) |=> pwm_o == $past(duty_lvl));

  assert_lock_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> ($stable(rel_period) && $stable(rel_duty)));

  assert_mid_cycle_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !wrap) |=> ($stable(act_period) && $stable(act_duty)));
endmodule

bind pwm_lock_gen pwm_lock_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run(run), .wrap(wrap), .lock(lock),
  .duty_lvl(duty_lvl), .idle_lvl(idle_lvl), .cnt(cnt),
  .act_period(act_period), .act_duty(act_duty),
  .rel_period(rel_period), .rel_duty(rel_duty), .pwm_o(pwm_o)
);

// File: tb/pwm_lock_gen_test.sv
module pwm_lock_gen_test;
  localparam int ADDR_W = 5;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] duty;
    logic        pol;
    logic [15:0] exp_hi;
  } vec_t;

  // expected high cycles per period (R5, R6)
  localparam vec_t VEC [NVEC] = '{
    '{16'd10, 16'd6,  1'b1, 16'd6},
    '{16'd10, 16'd6,  1'b0, 16'd4},
    '{16'd4,  16'd0,  1'b1, 16'd0},
    '{16'd5,  16'd5,  1'b1, 16'd5},
    '{16'd5,  16'd9,  1'b1, 16'd5},
    '{16'd8,  16'd1,  1'b1, 16'd1},
    '{16'd1,  16'd0,  1'b1, 16'd0},
    '{16'd1,  16'd1,  1'b1, 16'd1},
    '{16'd20, 16'd15, 1'b0, 16'd5},
    '{16'd40, 16'd24, 1'b1, 16'd24}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pwm;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pwm_lock_gen #(.CNT_W(16), .ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .pwm_o(pwm)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    paddr = a;
    #1 d = prdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1 if (pwm) hi++;
    end
  endtask

  // follow the counter; record the value before the first two wraps
  task automatic watch(input int n, output int w0, output int w1, output bit ok);
    logic [31:0] prev, cur;
    int nw;
    ok = 1'b1; w0 = -1; w1 = -1; nw = 0;
    rd(5'h00, prev);
    for (int i = 0; i < n; i++) begin
      rd(5'h00, cur);
      if (cur == 0 && prev != 0) begin
        if (nw == 0) w0 = int'(prev);
        else if (nw == 1) w1 = int'(prev);
        nw++;
      end else if (cur != prev + 1) ok = 1'b0;
      prev = cur;
    end
  endtask

  task automatic wait_cnt(input int v);
    logic [31:0] c;
    for (int i = 0; i < 200; i++) begin
      rd(5'h00, c);
      if (c == 32'(v)) break;
    end
  endtask

  initial begin
    #800000;
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hi, w0, w1;
    bit ok;

    // R1: reset state
    idle(3);
    rd(5'h00, d); check(d == 0, "R1", "counter in reset", d, 0);
    rd(5'h04, d); check(d == 0, "R1", "period in reset", d, 0);
    rd(5'h08, d); check(d == 0, "R1", "duty in reset", d, 0);
    rd(5'h0C, d); check(d == 0, "R1", "ctrl in reset", d, 0);
    check(pwm == 1'b0, "R1", "pwm in reset", pwm, 0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    check(pwm == 1'b0, "R1", "pwm after reset", pwm, 0);

    // vector table: R5, R6
    for (int v = 0; v < NVEC; v++) begin
      int p;
      p = int'(VEC[v].per);
      wr(5'h0C, 32'h0);
      wr(5'h04, 32'(VEC[v].per));
      wr(5'h08, 32'(VEC[v].duty));
      wr(5'h0C, 32'h3 | (32'(VEC[v].pol) << 3) | (32'(!VEC[v].pol) << 4));
      idle(4);
      count_high(4 * p, hi);
      check(hi == 4 * int'(VEC[v].exp_hi), "R5/R6", $sformatf("vector %0d high count", v),
            hi, 4 * int'(VEC[v].exp_hi));
    end

    // R2: control field mask and readback
    wr(5'h0C, 32'h0);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, d); check(d == 32'h5B, "R2", "ctrl readback mask (bits 0,1,3,4,6)", d, 32'h5B);
    wr(5'h0C, 32'h0);
    wr(5'h04, 32'd123);
    rd(5'h04, d); check(d == 123, "R2", "period readback", d, 123);
    wr(5'h08, 32'd45);
    rd(5'h08, d); check(d == 45, "R2", "duty readback", d, 45);

    // R10: ignored writes, unmapped reads
    wr(5'h10, 32'hFFFF);
    rd(5'h10, d); check(d == 0, "R10", "unmapped read", d, 0);
    wr(5'h05, 32'd77);
    rd(5'h04, d); check(d == 123, "R10", "period after unaligned write", d, 123);
    wr(5'h14, 32'd99);
    rd(5'h04, d); check(d == 123, "R10", "period after write above map", d, 123);
    wr(5'h00, 32'd5);
    rd(5'h00, d); check(d == 0, "R10", "counter write ignored", d, 0);

    // R3: only en+cont runs; idle level from bit 4
    wr(5'h04, 32'd6);
    wr(5'h08, 32'd3);
    wr(5'h0C, 32'h10);
    idle(2);
    check(pwm == 1'b1, "R3", "idle level high", pwm, 1);
    wr(5'h0C, 32'h11);
    idle(5);
    rd(5'h00, d); check(d == 0, "R3", "counter, enable only", d, 0);
    check(pwm == 1'b1, "R3", "pwm, enable only", pwm, 1);
    wr(5'h0C, 32'h12);
    idle(5);
    rd(5'h00, d); check(d == 0, "R3", "counter, continuous only", d, 0);
    check(pwm == 1'b1, "R3", "pwm, continuous only", pwm, 1);

    // R4: counter stepping and wrap
    wr(5'h0C, 32'h0);
    wr(5'h04, 32'd8);
    wr(5'h0C, 32'h0B);
    watch(20, w0, w1, ok);
    check(ok, "R4", "counter steps by one", ok, 1);
    check(w0 == 7 && w1 == 7, "R4", "wrap value", w0, 7);
    wr(5'h04, 32'd1);
    idle(12);
    hi = 0;
    for (int i = 0; i < 5; i++) begin
      rd(5'h00, d);
      if (d != 0) hi++;
    end
    check(hi == 0, "R4", "period 1 holds counter at 0", hi, 0);
    wr(5'h0C, 32'h18);
    idle(2);
    rd(5'h00, d); check(d == 0, "R3", "counter cleared on disable", d, 0);
    check(pwm == 1'b1, "R3", "idle level after disable", pwm, 1);

    // R7, R8: lock staging and release
    wr(5'h0C, 32'h0);
    wr(5'h04, 32'd10);
    wr(5'h08, 32'd2);
    wr(5'h0C, 32'h0B);
    idle(5);
    wr(5'h0C, 32'h4B);
    wr(5'h04, 32'd20);
    wr(5'h08, 32'd15);
    rd(5'h04, d); check(d == 20, "R7", "staged period readback", d, 20);
    rd(5'h08, d); check(d == 15, "R7", "staged duty readback", d, 15);
    watch(35, w0, w1, ok);
    check(ok && w0 == 9 && w1 == 9, "R7", "period held while locked", w1, 9);
    count_high(40, hi);
    check(hi == 8, "R7", "duty held while locked", hi, 8);
    wait_cnt(1);
    wr(5'h0C, 32'h0B);
    watch(40, w0, w1, ok);
    check(ok && w0 == 9, "R8", "current period completes", w0, 9);
    check(w1 == 19, "R8", "released period applies at wrap", w1, 19);
    count_high(80, hi);
    check(hi == 60, "R8", "released duty applies", hi, 60);

    // R9: unlocked update waits for wrap
    wait_cnt(1);
    wr(5'h04, 32'd6);
    watch(40, w0, w1, ok);
    check(ok && w0 == 19, "R9", "old period completes", w0, 19);
    check(w1 == 5, "R9", "new period after wrap", w1, 5);
    count_high(24, hi);
    check(hi == 24, "R6", "duty above period is constant active", hi, 24);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule